// File: doc/BRIEF.md
# Two-Wire Configuration Slave

This block lets a board-level two-wire master program the divider settings of a clock synthesizer. SCL and SDA are oversampled with the system clock through a short synchronizer, and bus events (start, stop, SCL edges) are derived from the synchronized levels. The slave answers one fixed 7-bit address. In a write, the first two bytes after the address are accepted and thrown away. The next three bytes are latched into configuration registers, and anything after them is acknowledged but has no effect. In a read, the three latched bytes are returned most significant bit first.

The first latched byte holds the Q-bypass flag, the P/Q source select flag and the 6-bit Q code. The second holds the 8-bit P code. The third is stored but has no function. SDA is open-drain: the block only asserts an enable that pulls the line low.

Controller states: IDLE (ignore the bus), ADDR (shift in address and R/W), ADDR_ACK (drive the address acknowledge), WR_BYTE (shift in a write byte), WR_ACK (drive a write acknowledge), RD_BYTE (shift out a latched byte), RD_ACK (release SDA and sample the master's acknowledge). Transitions:
- Any state goes to IDLE on stop and to ADDR on start.
- ADDR goes to ADDR_ACK when the eighth bit ends and the address matches, and to IDLE when it does not.
- ADDR_ACK goes to WR_BYTE (R/W 0) or RD_BYTE (R/W 1) on the SCL fall that ends the acknowledge.
- WR_BYTE goes to WR_ACK after eight bits, and WR_ACK goes back to WR_BYTE.
- RD_BYTE goes to RD_ACK after eight bits.
- RD_ACK goes to RD_BYTE on a master acknowledge and to IDLE on a not-acknowledge.

Top module: `cfg_twowire_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) begins a new address phase from any state, including in the middle of a transfer (repeated start).
- R2: A stop (SDA rising while SCL is high) returns the slave to idle with SDA released. Bytes clocked after it without a new start get no acknowledge and change no register.
- R3: The address byte is seven address bits, MSB first, then R/W (0 = write, 1 = read). Only address 1100101 is acknowledged. After any other address the slave does not drive SDA until the next start.
- R4: The acknowledge enable is low during the eighth bit. It rises after the SCL fall that ends that bit, stays high through the whole ninth SCL high period, and is released after the following SCL fall.
- R5: In a write, the two bytes after the address byte are acknowledged and leave every configuration output unchanged.
- R6: The third write byte after the address is latched at the end of its eighth bit: bit 7 to q_bypass, bit 6 to sel_pq, bits 5..0 to q_code.
- R7: The fourth write byte is latched into p_code (bits 7..0), and the fifth into rsvd_code.
- R8: Write bytes after the fifth are acknowledged and leave every configuration output unchanged.
- R9: In a read, the slave returns the three latched bytes in order, MSB first, while the master acknowledges. Further bytes read as 0xFF because SDA stays released.
- R10: A master not-acknowledge in a read makes the slave release SDA and ignore the bus until the next start.
- R11: After reset all configuration outputs are zero and sda_oe is low.
- R12: sda_oe changes only while SCL is low, except as a result of a start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| q_bypass | output | 1 | Q divider bypass flag |
| sel_pq | output | 1 | Use programmed P/Q instead of the pin-selected ratio |
| q_code | output | 6 | Q divider code |
| p_code | output | 8 | P divider code |
| rsvd_code | output | 8 | Stored reserved byte |

## Verification
The embedded assertions check on every cycle that a stop leaves the controller idle with SDA released, and that a start restarts the address phase. They also check that a mismatched address or a master not-acknowledge releases SDA, that the SDA enable never moves during an SCL high period outside start and stop, and that the registers change only on a write strobe aimed at an existing register. What only the bench scenarios show is the protocol seen from the wire. That covers the full 128-address sweep, the ordering of the dummy, data and excess bytes, the field split of the first data byte, readback contents including the 0xFF tail, and the bus staying silent after a stop or a not-acknowledge.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } tws_state_e;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ch;
    logic [STAGES-1:0] sda_ch;
    logic              scl_d;
    logic              sda_d;

    // idle bus is high on both lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ch <= '1;
            sda_ch <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ch <= {scl_ch[STAGES-2:0], scl_in};
            sda_ch <= {sda_ch[STAGES-2:0], sda_in};
            scl_d  <= scl_ch[STAGES-1];
            sda_d  <= sda_ch[STAGES-1];
        end
    end

    assign scl_lvl   = scl_ch[STAGES-1];
    assign sda_lvl   = sda_ch[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_d;
    assign scl_fall  = ~scl_lvl & scl_d;
    assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/tws_regbank.sv
module tws_regbank #(
    parameter int NUM_DATA = 3,
    localparam int DIDX_W = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1,
    localparam int RIDX_W = $clog2(NUM_DATA + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [DIDX_W-1:0]             wr_idx,
    input  logic [tws_pkg::BYTE_W-1:0]    wr_data,
    input  logic [RIDX_W-1:0]             rd_idx,
    output logic [tws_pkg::BYTE_W-1:0]    rd_data,
    output logic [NUM_DATA-1:0][tws_pkg::BYTE_W-1:0] regs_o
);
    logic [tws_pkg::BYTE_W-1:0] regs [NUM_DATA];

    for (genvar g = 0; g < NUM_DATA; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_idx == DIDX_W'(g))
                regs[g] <= wr_data;
        end
        assign regs_o[g] = regs[g];
    end

    // past the last register the line stays released, which reads as ones
    always_comb begin
        rd_data = '1;
        for (int i = 0; i < NUM_DATA; i++)
            if (rd_idx == RIDX_W'(i))
                rd_data = regs[i];
    end

    a_r8_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(regs_o));

    a_r7_wr_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NUM_DATA));

endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
    import tws_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'b1100101,
    parameter int         NUM_DUMMY = 2,
    parameter int         NUM_DATA  = 3,
    localparam int TOTAL  = NUM_DUMMY + NUM_DATA,
    localparam int WIDX_W = $clog2(TOTAL + 1),
    localparam int DIDX_W = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1,
    localparam int RIDX_W = $clog2(NUM_DATA + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_lvl,
    input  logic                sda_lvl,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic [RIDX_W-1:0]   rd_idx,
    output logic                wr_en,
    output logic [DIDX_W-1:0]   wr_idx,
    output logic [BYTE_W-1:0]   wr_data,
    output logic                sda_oe
);
    tws_state_e        state, nxt;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              rw;
    logic              mack;
    logic [WIDX_W-1:0] wbyte;
    logic [RIDX_W-1:0] rbyte;
    logic              byte_done;
    logic              tx_msb_nxt;

    assign byte_done = scl_fall && (bit_cnt == 4'd8);

    // next-state decision
    always_comb begin
        nxt = state;
        if (stop_det)
            nxt = ST_IDLE;
        else if (start_det)
            nxt = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_done)
                                 nxt = (shreg[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) nxt = rw ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_done) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bit_cnt == 4'd7) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = mack ? ST_RD_BYTE : ST_IDLE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // write strobe toward the register bank
    always_comb begin
        wr_en   = (state == ST_WR_BYTE) && byte_done && !start_det && !stop_det &&
                  (wbyte >= WIDX_W'(NUM_DUMMY)) && (wbyte < WIDX_W'(TOTAL));
        wr_idx  = DIDX_W'(wbyte - WIDX_W'(NUM_DUMMY));
        wr_data = shreg;
        rd_idx  = rbyte;
    end

    // bit that will sit on SDA once the state register has moved
    always_comb begin
        if (state == ST_ADDR_ACK || state == ST_RD_ACK)
            tx_msb_nxt = rd_data[BYTE_W-1];
        else if (state == ST_RD_BYTE && scl_fall)
            tx_msb_nxt = txreg[BYTE_W-2];
        else
            tx_msb_nxt = txreg[BYTE_W-1];
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '1;
            rw      <= 1'b0;
            mack    <= 1'b0;
            wbyte   <= '0;
            rbyte   <= '0;
        end else begin
            state <= nxt;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
                wbyte   <= '0;
                rbyte   <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (byte_done && state == ST_ADDR)
                            rw <= shreg[0];
                        if (byte_done && state == ST_WR_BYTE && wbyte != WIDX_W'(TOTAL))
                            wbyte <= wbyte + 1'b1;
                    end
                    ST_ADDR_ACK, ST_WR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR_ACK && rw) begin
                                txreg <= rd_data;
                                if (rbyte != RIDX_W'(NUM_DATA)) rbyte <= rbyte + 1'b1;
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            txreg   <= {txreg[BYTE_W-2:0], 1'b1};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mack <= ~sda_lvl;
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (mack) begin
                                txreg <= rd_data;
                                if (rbyte != RIDX_W'(NUM_DATA)) rbyte <= rbyte + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // open-drain output enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sda_oe <= 1'b0;
        else
            sda_oe <= (nxt == ST_ADDR_ACK) || (nxt == ST_WR_ACK) ||
                      ((nxt == ST_RD_BYTE) && !tx_msb_nxt);
    end

    a_r1_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_ADDR && bit_cnt == 4'd0));

    a_r2_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    a_r3_nomatch_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && byte_done && shreg[7:1] != DEV_ADDR && !start_det && !stop_det)
        |=> !sda_oe);

    a_r10_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_fall && !mack && !start_det && !stop_det)
        |=> (!sda_oe && state == ST_IDLE));

    a_r12_oe_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_lvl) && scl_lvl && !$past(start_det) && !$past(stop_det))
        |-> $stable(sda_oe));

endmodule

// File: rtl/cfg_twowire_slave.sv
module cfg_twowire_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'b1100101,
    parameter int         NUM_DUMMY   = 2,
    parameter int         NUM_DATA    = 3,
    parameter int         SYNC_STAGES = 2,
    localparam int DIDX_W = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1,
    localparam int RIDX_W = $clog2(NUM_DATA + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    output logic       q_bypass,
    output logic       sel_pq,
    output logic [5:0] q_code,
    output logic [7:0] p_code,
    output logic [7:0] rsvd_code
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic                        wr_en;
    logic [DIDX_W-1:0]           wr_idx;
    logic [tws_pkg::BYTE_W-1:0]  wr_data;
    logic [RIDX_W-1:0]           rd_idx;
    logic [tws_pkg::BYTE_W-1:0]  rd_data;
    logic [NUM_DATA-1:0][tws_pkg::BYTE_W-1:0] regs;

    tws_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    tws_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_DUMMY(NUM_DUMMY), .NUM_DATA(NUM_DATA)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_data(rd_data), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
    );

    tws_regbank #(.NUM_DATA(NUM_DATA)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(regs)
    );

    // field split of the latched bytes
    assign q_bypass  = regs[0][7];
    assign sel_pq    = regs[0][6];
    assign q_code    = regs[0][5:0];
    assign p_code    = regs[1];
    assign rsvd_code = regs[2];

endmodule

// File: tb/test_cfg_twowire_slave.sv
module test_cfg_twowire_slave;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 6;
    localparam int WATCHDOG   = 180000;
    localparam logic [7:0] WR_ADDR = 8'hCA;
    localparam logic [7:0] RD_ADDR = 8'hCB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, q_bypass, sel_pq;
    logic [5:0] q_code;
    logic [7:0] p_code, rsvd_code;
    logic sda_line;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int oe_viol = 0;
    logic prev_scl = 1'b1;
    logic prev_oe  = 1'b0;
    logic [7:0] e0 = 8'h00, e1 = 8'h00, e2 = 8'h00;

    assign sda_line = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_twowire_slave i_cfg_twowire_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .q_bypass(q_bypass), .sel_pq(sel_pq),
        .q_code(q_code), .p_code(p_code), .rsvd_code(rsvd_code)
    );

    always @(posedge clk) cycles <= cycles + 1;

    // R12 monitor: enable must not move across an SCL high stretch
    always @(negedge clk) begin
        if (rst_n && m_scl && prev_scl && sda_oe != prev_oe) oe_viol++;
        prev_scl = m_scl;
        prev_oe  = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_cfg(input string req);
        chk({q_bypass, sel_pq, q_code} == e0, req, {q_bypass, sel_pq, q_code}, e0);
        chk(p_code == e1, req, p_code, e1);
        chk(rsvd_code == e2, req, rsvd_code, e2);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; tick(QTR);
        m_scl = 1'b1; tick(QTR);
        m_sda = 1'b0; tick(QTR);
        m_scl = 1'b0; tick(QTR);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(QTR);
        m_scl = 1'b1; tick(QTR);
        m_sda = 1'b1; tick(QTR);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack,
                             output bit pre_oe, output bit hold_oe);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(QTR);
            m_scl = 1'b1; tick(QTR);
            if (i == 0) pre_oe = sda_oe;
            tick(QTR);
            m_scl = 1'b0; tick(QTR);
        end
        m_sda = 1'b1; tick(QTR);
        m_scl = 1'b1; tick(QTR);
        ack = !sda_line;
        tick(QTR - 1);
        hold_oe = sda_oe;
        tick(1);
        m_scl = 1'b0; tick(QTR);
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; tick(QTR);
            m_scl = 1'b1; tick(QTR);
            b[i] = sda_line;
            tick(QTR);
            m_scl = 1'b0; tick(QTR);
        end
        m_sda = nack; tick(QTR);
        m_scl = 1'b1; tick(2*QTR);
        m_scl = 1'b0; tick(QTR);
        m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                            input int extra);
        bit ack, po, ho;
        bus_start();
        send_byte(WR_ADDR, ack, po, ho);
        chk(ack, "R3", ack, 1);
        send_byte(8'h5A, ack, po, ho);
        chk(ack, "R5", ack, 1);
        send_byte(8'hA5, ack, po, ho);
        chk(ack, "R5", ack, 1);
        chk_cfg("R5");
        send_byte(d0, ack, po, ho);
        e0 = d0;
        chk(ack, "R6", ack, 1);
        chk({q_bypass, sel_pq, q_code} == d0, "R6", {q_bypass, sel_pq, q_code}, d0);
        send_byte(d1, ack, po, ho);
        e1 = d1;
        chk(ack && p_code == d1, "R7", p_code, d1);
        send_byte(d2, ack, po, ho);
        e2 = d2;
        chk(ack && rsvd_code == d2, "R7", rsvd_code, d2);
        for (int k = 0; k < extra; k++) begin
            send_byte(8'h11 * (k + 1), ack, po, ho);
            chk(ack, "R8", ack, 1);
            chk_cfg("R8");
        end
        bus_stop();
    endtask

    task automatic do_read;
        bit ack, po, ho;
        logic [7:0] b;
        bus_start();
        send_byte(RD_ADDR, ack, po, ho);
        chk(ack, "R3", ack, 1);
        recv_byte(1'b0, b); chk(b == e0, "R9", b, e0);
        recv_byte(1'b0, b); chk(b == e1, "R9", b, e1);
        recv_byte(1'b0, b); chk(b == e2, "R9", b, e2);
        recv_byte(1'b1, b); chk(b == 8'hFF, "R9", b, 8'hFF);
        bus_stop();
    endtask

    task automatic run_all;
        bit ack, po, ho;
        logic [7:0] b;
        // R11: reset state
        tick(5);
        chk(sda_oe == 1'b0, "R11", sda_oe, 0);
        chk_cfg("R11");
        rst_n = 1'b1;
        tick(5);
        chk(sda_oe == 1'b0, "R11", sda_oe, 0);

        // R3/R4: sweep every 7-bit address with R/W = 0
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({a[6:0], 1'b0}, ack, po, ho);
            chk(ack == (a == 7'h65), "R3", ack, a == 7'h65);
            if (a == 7'h65) begin
                chk(po == 1'b0, "R4", po, 0);
                chk(ho == 1'b1, "R4", ho, 1);
                chk(sda_oe == 1'b0, "R4", sda_oe, 0);
            end
            if (a == 7'h64 || a == 7'h25 || a == 7'h45) begin
                send_byte(WR_ADDR, ack, po, ho);
                chk(!ack, "R3", ack, 0);
            end
            bus_stop();
        end

        // R5..R7 and R9: sweep of configuration values with periodic readback
        for (int i = 0; i < 40; i++) begin
            do_write(8'((i * 37 + 11) & 255), 8'((i * 91 + 3) & 255), ~8'((i * 53) & 255), 0);
            if (i % 4 == 3) do_read();
        end

        // R8: bytes past the third are acknowledged and dropped
        do_write(8'hC3, 8'h7E, 8'h81, 3);
        chk_cfg("R8");
        do_read();

        // R1: repeated start in the middle of a write
        bus_start();
        send_byte(WR_ADDR, ack, po, ho);
        send_byte(8'h00, ack, po, ho);
        send_byte(8'h00, ack, po, ho);
        send_byte(8'h3C, ack, po, ho);
        e0 = 8'h3C;
        bus_start();
        chk_cfg("R1");
        send_byte(WR_ADDR, ack, po, ho);
        chk(ack, "R1", ack, 1);
        send_byte(8'hFF, ack, po, ho);
        send_byte(8'hFF, ack, po, ho);
        chk_cfg("R1");
        send_byte(8'h45, ack, po, ho); e0 = 8'h45;
        send_byte(8'h9A, ack, po, ho); e1 = 8'h9A;
        bus_stop();
        chk_cfg("R1");

        // R2: after a stop the slave ignores bytes without a start
        send_byte(WR_ADDR, ack, po, ho);
        chk(!ack, "R2", ack, 0);
        send_byte(8'h00, ack, po, ho);
        chk(!ack, "R2", ack, 0);
        chk(sda_oe == 1'b0, "R2", sda_oe, 0);
        chk_cfg("R2");

        // R10: not-acknowledge ends the read; further clocks read released line
        bus_start();
        send_byte(RD_ADDR, ack, po, ho);
        recv_byte(1'b1, b);
        chk(b == e0, "R10", b, e0);
        recv_byte(1'b1, b);
        chk(b == 8'hFF, "R10", b, 8'hFF);
        chk(sda_oe == 1'b0, "R10", sda_oe, 0);
        bus_stop();

        // R12: monitor result
        chk(oe_viol == 0, "R12", oe_viol, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                wait (cycles >= WATCHDOG);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule